// File: doc/BRIEF.md
# Low-speed USB packet transmitter

This block drives a packet onto a low-speed USB wire pair. When a transmit request arrives it first parks the pair at the idle J level and then turns on the drivers. It sends a sync byte, then the packet bytes it reads one at a time from an external byte store. Every bit goes out least significant bit first, NRZI coded, with a stuffed zero after any six ones in a row. It then ends the packet with two bit times of SE0 and one bit time of J, and releases both lines. A separate shortcut request sends a two-byte handshake (sync plus an ACK or NAK PID) without touching the byte store.

The block also holds a pending device address. Software writes this address at any time, but the address only becomes the active address when a data packet has been fully sent. A handshake reply leaves the active address unchanged. A receive-start flag, raised by edges seen on the bus (including the block's own transmission), is cleared when the block releases the bus.

Bit timing comes from a divider of the system clock (11 clocks per bit by default). The next byte is taken from the store while the last bit of the current byte is being launched, so consecutive bytes go out with no gap.

Top module: `lsusb_tx`

## Requirements
- R1: After reset the block is idle: `usb_oe`=0, `usb_dp`=0, `usb_dm`=0, `busy`=0, `done`=0, `rx_pending`=0, `active_addr`=0.
- R2: A request accepted at a clock edge gives one cycle with `usb_dp`=0, `usb_dm`=1 (J) and `usb_oe`=0. In the next cycle `usb_oe` rises and the first packet bit is on the lines.
- R3: The first byte sent is the sync byte 0x80. Every byte is sent bit 0 first, and each line bit lasts BIT_CLKS (11) clock cycles.
- R4: Data lines are NRZI coded, starting from J. A 0 bit switches between J ({dp,dm}=01) and K ({dp,dm}=10), and a 1 bit keeps the previous level.
- R5: After six consecutive 1 bits the block inserts one extra line bit that switches level. The run of ones carries across byte boundaries, and a stuffed bit is still sent when the six ones end the last byte.
- R6: `tx_start` sends a packet of `tx_len` bytes in total, including sync. Values below 2 are treated as 2 and values above 12 as 12. Payload byte k is read from `rd_data` while `rd_addr`=k, for k = 0 up to length-2.
- R7: `hs_start` sends sync followed by the PID 0x5A (NAK) when `hs_nak`=1, or 0xD2 (ACK) when `hs_nak`=0. If both requests arrive together, `tx_start` wins.
- R8: After the last bit, the lines carry SE0 ({dp,dm}=00, `usb_oe`=1) for two bit times, then J for one bit time. In the following cycle `usb_oe`=0, both lines are 0, and `done` is high for exactly that one cycle.
- R9: `addr_wr` loads `addr_wdata` into the pending address. The pending address is copied to `active_addr` in the release cycle of a data packet, never after a handshake packet.
- R10: `rx_edge` sets `rx_pending` and `rx_ack` clears it. Releasing the bus clears it even if `rx_edge` was raised during the packet.
- R11: `busy` is high from the cycle after acceptance until the release cycle. Any `tx_start` or `hs_start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Request to send a data packet |
| tx_len | input | LEN_W (4) | Total packet length in bytes, sync included |
| hs_start | input | 1 | Request to send a handshake packet |
| hs_nak | input | 1 | Handshake select: 1 = NAK, 0 = ACK |
| rd_addr | output | IDX_W (4) | Index of the payload byte to be fetched |
| rd_data | input | 8 | Payload byte at `rd_addr`, combinational |
| addr_wr | input | 1 | Write strobe for the pending device address |
| addr_wdata | input | ADDR_W (7) | New device address |
| active_addr | output | ADDR_W (7) | Device address currently in force |
| rx_edge | input | 1 | Bus activity seen by the receive edge detector |
| rx_ack | input | 1 | Clears the receive-start flag |
| rx_pending | output | 1 | Receive-start flag |
| usb_dp | output | 1 | D+ drive value |
| usb_dm | output | 1 | D- drive value |
| usb_oe | output | 1 | Output enable for both lines |
| busy | output | 1 | Transmission in progress |
| done | output | 1 | One-cycle pulse on bus release |

## Verification
The hardest situation to reach from the ports is a stuffed bit that falls across a byte boundary or right after the final payload bit. The stimulus builds this from payloads such as all-ones bytes, 0x3F right after the sync byte, and a last byte of 0xFC. A second hard case is a new request, plus bus activity, arriving in the middle of a packet. The bench injects both while the packet is being serialized. It then checks that the line stream stays intact, that only one release pulse appears, and that the receive flag ends up clear. The address commit is tested by writing a new address and then sending handshakes before and after a data packet.

// File: rtl/lsusb_tx_pkg.sv
// Shared definitions for the low-speed transmitter: controller states and
// the fixed byte values placed on the wire by the block itself.
package lsusb_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // bus released
        ST_ARM  = 3'd1,   // lines at J, drivers still off
        ST_SEND = 3'd2,   // serialising sync and payload bits
        ST_SE0  = 3'd3,   // end of packet, both lines low
        ST_EOPJ = 3'd4    // end of packet, idle J before release
    } tx_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'h80;
    localparam logic [7:0] PID_ACK   = 8'hD2;
    localparam logic [7:0] PID_NAK   = 8'h5A;

endpackage

// File: rtl/lsusb_bit_timer.sv
// Bit-period divider. While run is high it counts BIT_CLKS cycles per line
// bit and raises tick in the last cycle of each bit. Dropping run clears the
// count, so the first cycle of a run is cycle 0 of a bit.
// Assumes BIT_CLKS >= 2.
module lsusb_bit_timer #(
    parameter int BIT_CLKS = 11,
    localparam int CW = $clog2(BIT_CLKS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(BIT_CLKS - 1));

    // Cycle counter within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R3: bit boundaries are never adjacent.
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/lsusb_nrzi_stuffer.sv
// NRZI coder with bit stuffing. Holds the current line level (1 = J,
// 0 = K) and the length of the current run of ones. At each launch it
// either inserts a stuffed transition (when the run reached RUN_MAX) or
// codes data_bit. consumed tells the caller whether data_bit was used.
// Assumes init and launch are never high together.
module lsusb_nrzi_stuffer #(
    parameter int RUN_MAX = 6,
    localparam int RW = $clog2(RUN_MAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic launch,
    input  logic data_bit,
    output logic stuff_due,
    output logic consumed,
    output logic level
);

    logic [RW-1:0] ones;

    assign stuff_due = (ones == RW'(RUN_MAX));
    assign consumed  = launch && !stuff_due;

    // Line level and run length update per launched bit.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            level <= 1'b1;
            ones  <= '0;
        end else if (launch) begin
            if (stuff_due || !data_bit) begin
                level <= ~level;
                ones  <= '0;
            end else begin
                ones  <= ones + RW'(1);
            end
        end
    end

    // R5: the run of ones never grows beyond the stuffing limit.
    a_r5_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        ones <= RW'(RUN_MAX));

    // R4: a coded 1 keeps the line level.
    a_r4_one_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed && data_bit) |=> $stable(level));

    // R4/R5: a coded 0 or a stuffed bit switches the level.
    a_r4_zero_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && (stuff_due || !data_bit)) |=> (level != $past(level)));

endmodule

// File: rtl/lsusb_addr_reg.sv
// Device address holder. A write lands in the pending register at once.
// The active register follows the pending one only on commit, which the
// controller raises at the end of a data packet.
module lsusb_addr_reg #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              commit,
    output logic [ADDR_W-1:0] active
);

    logic [ADDR_W-1:0] pending;

    // Pending address capture.
    always_ff @(posedge clk) begin
        if (!rst_n)  pending <= '0;
        else if (wr) pending <= wr_data;
    end

    // Deferred transfer into the active address.
    always_ff @(posedge clk) begin
        if (!rst_n)      active <= '0;
        else if (commit) active <= pending;
    end

    // R9: the active address only moves on a commit.
    a_r9_moves_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(active) |-> $past(commit));

endmodule

// File: rtl/lsusb_tx.sv
// Low-speed USB packet transmitter, top level. It sequences arm, bit
// serialisation, end of packet and bus release, and it fetches payload bytes
// from an external store. It also owns the deferred address commit and the
// receive-start flag. Assumes rd_data is valid in the same cycle as
// rd_addr and that the line levels are decoded outside as {dp,dm}.
module lsusb_tx
    import lsusb_tx_pkg::*;
#(
    parameter int BIT_CLKS  = 11,
    parameter int MAX_BYTES = 12,
    parameter int ADDR_W    = 7,
    parameter int RUN_MAX   = 6,
    localparam int LEN_W = $clog2(MAX_BYTES + 1),
    localparam int IDX_W = $clog2(MAX_BYTES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [LEN_W-1:0]  tx_len,
    input  logic              hs_start,
    input  logic              hs_nak,
    output logic [IDX_W-1:0]  rd_addr,
    input  logic [7:0]        rd_data,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    output logic [ADDR_W-1:0] active_addr,
    input  logic              rx_edge,
    input  logic              rx_ack,
    output logic              rx_pending,
    output logic              usb_dp,
    output logic              usb_dm,
    output logic              usb_oe,
    output logic              busy,
    output logic              done
);

    tx_state_t         st;
    logic [7:0]        shreg;
    logic [2:0]        bit_idx;
    logic [LEN_W-1:0]  bytes_left;
    logic [LEN_W-1:0]  eff_len;
    logic [IDX_W-1:0]  rd_addr_q;
    logic [7:0]        hs_pid;
    logic              is_hs;
    logic              bits_left;
    logic              eop_second;
    logic              tick;
    logic              launch;
    logic              stuff_due;
    logic              consumed;
    logic              level;
    logic              release_now;

    assign rd_addr     = rd_addr_q;
    assign busy        = (st != ST_IDLE);
    assign launch      = (st == ST_ARM) || ((st == ST_SEND) && tick);
    assign release_now = (st == ST_EOPJ) && tick;

    // Clamp the requested packet length into the legal range.
    always_comb begin
        if (tx_len < LEN_W'(2))              eff_len = LEN_W'(2);
        else if (tx_len > LEN_W'(MAX_BYTES)) eff_len = LEN_W'(MAX_BYTES);
        else                                 eff_len = tx_len;
    end

    lsusb_bit_timer #(.BIT_CLKS(BIT_CLKS)) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((st == ST_SEND) || (st == ST_SE0) || (st == ST_EOPJ)),
        .tick  (tick)
    );

    lsusb_nrzi_stuffer #(.RUN_MAX(RUN_MAX)) coder_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .init      (st == ST_IDLE),
        .launch    (launch),
        .data_bit  (shreg[0]),
        .stuff_due (stuff_due),
        .consumed  (consumed),
        .level     (level)
    );

    lsusb_addr_reg #(.ADDR_W(ADDR_W)) addr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (addr_wr),
        .wr_data (addr_wdata),
        .commit  (release_now && !is_hs),
        .active  (active_addr)
    );

    // Drive values of the pair for each controller state.
    always_comb begin
        case (st)
            ST_ARM:  begin usb_oe = 1'b0; usb_dp = 1'b0;   usb_dm = 1'b1;  end
            ST_SEND: begin usb_oe = 1'b1; usb_dp = ~level; usb_dm = level; end
            ST_SE0:  begin usb_oe = 1'b1; usb_dp = 1'b0;   usb_dm = 1'b0;  end
            ST_EOPJ: begin usb_oe = 1'b1; usb_dp = 1'b0;   usb_dm = 1'b1;  end
            default: begin usb_oe = 1'b0; usb_dp = 1'b0;   usb_dm = 1'b0;  end
        endcase
    end

    // Packet sequencing and byte/bit bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            shreg      <= '0;
            bit_idx    <= '0;
            bytes_left <= '0;
            rd_addr_q  <= '0;
            hs_pid     <= '0;
            is_hs      <= 1'b0;
            bits_left  <= 1'b0;
            eop_second <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (tx_start || hs_start) begin
                        st         <= ST_ARM;
                        shreg      <= SYNC_BYTE;
                        bit_idx    <= '0;
                        rd_addr_q  <= '0;
                        bits_left  <= 1'b1;
                        is_hs      <= !tx_start;
                        bytes_left <= tx_start ? (eff_len - LEN_W'(1)) : LEN_W'(1);
                        hs_pid     <= hs_nak ? PID_NAK : PID_ACK;
                    end
                end
                ST_ARM: st <= ST_SEND;
                ST_SEND: begin
                    if (tick && !stuff_due && !bits_left) begin
                        st         <= ST_SE0;
                        eop_second <= 1'b0;
                    end
                end
                ST_SE0: begin
                    if (tick) begin
                        if (eop_second) st <= ST_EOPJ;
                        else            eop_second <= 1'b1;
                    end
                end
                ST_EOPJ: begin
                    if (tick) begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase

            if (consumed && bits_left) begin
                if (bit_idx == 3'd7) begin
                    if (bytes_left != '0) begin
                        shreg      <= is_hs ? hs_pid : rd_data;
                        bytes_left <= bytes_left - LEN_W'(1);
                        bit_idx    <= '0;
                        if (!is_hs && (bytes_left > LEN_W'(1)))
                            rd_addr_q <= rd_addr_q + IDX_W'(1);
                    end else begin
                        bits_left <= 1'b0;
                    end
                end else begin
                    shreg   <= {1'b0, shreg[7:1]};
                    bit_idx <= bit_idx + 3'd1;
                end
            end
        end
    end

    // Receive-start flag: set by bus activity, cleared by ack or release.
    always_ff @(posedge clk) begin
        if (!rst_n)           rx_pending <= 1'b0;
        else if (release_now) rx_pending <= 1'b0;
        else if (rx_edge)     rx_pending <= 1'b1;
        else if (rx_ack)      rx_pending <= 1'b0;
    end

    // R2: drivers come on only after a cycle at J.
    a_r2_j_before_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(usb_oe) |-> ($past(usb_dp) == 1'b0 && $past(usb_dm) == 1'b1));

    // R8: release pulse lasts one cycle.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: released lines carry no drive value.
    a_r8_released_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!usb_oe && !usb_dp && !usb_dm));

    // R11: busy ends together with the release pulse.
    a_r11_busy_drops_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R10: the flag is clear when the bus is released.
    a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !rx_pending);

    // R6: payload reads stay inside the legal index range.
    a_r6_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr <= IDX_W'(MAX_BYTES - 2));

endmodule

// File: tb/lsusb_tx_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver builds the expected line symbols of each
// packet into a queue; the monitor samples mid-bit and compares.
module lsusb_tx_tb_top;

    localparam int BIT = 11;
    localparam logic [1:0] SYM_J = 2'b01, SYM_K = 2'b10, SYM_SE0 = 2'b00;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0, hs_start = 1'b0, hs_nak = 1'b0;
    logic [3:0] tx_len = 4'd2;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;
    logic       addr_wr = 1'b0;
    logic [6:0] addr_wdata = '0;
    logic [6:0] active_addr;
    logic       rx_edge = 1'b0, rx_ack = 1'b0;
    logic       rx_pending, usb_dp, usb_dm, usb_oe, busy, done;

    logic [7:0] mem [0:15];
    assign rd_data = mem[rd_addr];

    always #4 clk = ~clk;

    lsusb_tx dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len),
        .hs_start(hs_start), .hs_nak(hs_nak), .rd_addr(rd_addr),
        .rd_data(rd_data), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .active_addr(active_addr), .rx_edge(rx_edge), .rx_ack(rx_ack),
        .rx_pending(rx_pending), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .usb_oe(usb_oe), .busy(busy), .done(done)
    );

    int errors = 0;
    int checks = 0;
    int pkt_seen = 0;
    logic [1:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] pkt [0:15];
    int         pkt_n;
    logic       m_level;
    int         m_ones;
    logic [6:0] exp_active = '0;
    logic [6:0] exp_pending = '0;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push_sym(input logic [1:0] s, input string tag);
        exp_q.push_back(s);
        tag_q.push_back(tag);
    endtask

    // Reference model: NRZI with stuffing over pkt[0..pkt_n-1], then EOP.
    task automatic build_expected();
        m_level = 1'b1;
        m_ones  = 0;
        for (int i = 0; i < pkt_n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (pkt[i][b] == 1'b0) begin m_level = ~m_level; m_ones = 0; end
                else m_ones++;
                push_sym(m_level ? SYM_J : SYM_K, "R4 data bit");
                if (m_ones == 6) begin
                    m_level = ~m_level; m_ones = 0;
                    push_sym(m_level ? SYM_J : SYM_K, "R5 stuffed bit");
                end
            end
        end
        push_sym(SYM_SE0, "R8 eop se0");
        push_sym(SYM_SE0, "R8 eop se0");
        push_sym(SYM_J,   "R8 eop j");
    endtask

    // Monitor: find driver enable, then sample each bit in its middle.
    initial begin
        forever begin
            do @(negedge clk); while (!usb_oe);
            repeat (5) @(negedge clk);
            while (exp_q.size() != 0) begin
                logic [1:0] s;
                string t;
                s = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {usb_oe, usb_dp, usb_dm}, {1'b1, s});
                if (exp_q.size() != 0) repeat (BIT) @(negedge clk);
            end
            repeat (6) @(negedge clk);
            check("R8 release oe", usb_oe, 0);
            check("R8 release done", done, 1);
            check("R8 release lines", {usb_dp, usb_dm}, 0);
            pkt_seen++;
        end
    end

    task automatic write_addr(input logic [6:0] v);
        @(negedge clk); addr_wr = 1'b1; addr_wdata = v;
        @(negedge clk); addr_wr = 1'b0;
        exp_pending = v;
    endtask

    // Driver: queue expectations, issue the request, await release.
    task automatic run_packet(input bit hs, input bit nak, input int len_req,
                              input bit poke_mid);
        int target;
        int n;
        target = pkt_seen + 1;
        pkt[0] = 8'h80;
        if (hs) begin
            pkt_n = 2;
            pkt[1] = nak ? 8'h5A : 8'hD2;
        end else begin
            n = (len_req < 2) ? 2 : ((len_req > 12) ? 12 : len_req);
            pkt_n = n;
            for (int i = 1; i < n; i++) pkt[i] = mem[i-1];
        end
        build_expected();
        @(negedge clk);
        if (hs) begin hs_start = 1'b1; hs_nak = nak; end
        else begin tx_start = 1'b1; tx_len = 4'(len_req); end
        @(negedge clk);
        tx_start = 1'b0; hs_start = 1'b0;
        check("R2 arm J", {usb_oe, usb_dp, usb_dm}, 3'b001);
        check("R11 busy after accept", busy, 1);
        if (poke_mid) begin
            repeat (40) @(negedge clk);
            tx_start = 1'b1; hs_start = 1'b1; rx_edge = 1'b1; tx_len = 4'd3;
            @(negedge clk);
            tx_start = 1'b0; hs_start = 1'b0; rx_edge = 1'b0;
            check("R10 flag set during tx", rx_pending, 1);
            check("R11 busy mid packet", busy, 1);
        end
        wait (pkt_seen == target);
        @(negedge clk);
        if (!hs) exp_active = exp_pending;
        check("R11 idle after release", busy, 0);
        check("R8 done single", done, 0);
        check("R9 active address", active_addr, exp_active);
        if (poke_mid) check("R10 flag cleared at release", rx_pending, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset oe", usb_oe, 0);
        check("R1 reset lines", {usb_dp, usb_dm}, 0);
        check("R1 reset busy/done", {busy, done}, 0);
        check("R1 reset flag", rx_pending, 0);
        check("R1 reset address", active_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: flag outside transmission
        rx_edge = 1'b1; @(negedge clk); rx_edge = 1'b0;
        check("R10 edge sets flag", rx_pending, 1);
        rx_ack = 1'b1; @(negedge clk); rx_ack = 1'b0;
        check("R10 ack clears flag", rx_pending, 0);

        // R7 handshakes do not commit the address (R9)
        write_addr(7'h2A);
        run_packet(1'b1, 1'b0, 0, 1'b0);
        run_packet(1'b1, 1'b1, 0, 1'b0);

        // R3/R4 mixed payload, commits the address
        mem[0] = 8'h3C; mem[1] = 8'hA5; mem[2] = 8'h00;
        run_packet(1'b0, 1'b0, 4, 1'b0);

        // R5 all ones at maximum length, with mid-packet requests (R11, R10)
        for (int i = 0; i < 11; i++) mem[i] = 8'hFF;
        run_packet(1'b0, 1'b0, 12, 1'b1);

        // R6 short length clamps to 2; run crosses sync boundary
        mem[0] = 8'h3F;
        run_packet(1'b0, 1'b0, 1, 1'b0);

        // R6 long length clamps to 12
        for (int i = 0; i < 11; i++) mem[i] = 8'(i * 37 + 5);
        run_packet(1'b0, 1'b0, 15, 1'b0);

        // R5 stuffed bit after the final payload bit
        mem[0] = 8'hFC;
        run_packet(1'b0, 1'b0, 2, 1'b0);

        // R9 new address, handshake leaves it pending
        write_addr(7'h11);
        run_packet(1'b1, 1'b0, 0, 1'b0);
        check("R9 handshake keeps address", active_addr, 7'h2A);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule